// File: doc/BRIEF.md
# Single-Pin Trim Code Controller

This block is the digital core of a one-pin trim adjustment. Comparators outside the block classify a single control pin as low, mid, high or program level and present those four levels as synchronous flags. The block keeps a 7-bit trim code. It raises the code by one when the pin moves from mid to high and lowers it by one when the pin moves from mid to low. The code stops at both ends of its range.

A program-level condition held for longer than a qualification window, 200 µs of system clock, starts one write of the current code to a non-volatile store. The store sits behind a request/busy handshake. After reset the block reads the store back. It loads the returned code, or mid-scale when the store reports blank, before it accepts any step. Steps and program commands count only while chip enable is high and no store access is in progress.

Top module: `trim_ctl_top`

## Requirements
- R1: After reset, `nv_rd_req` is high until `nv_rd_valid` is seen. On that edge `trim_code` takes `nv_rd_data`, or 64 when `nv_rd_blank` is high. Step levels seen before the load do not change the code.
- R2: While stepping is enabled and the pin was last at mid, the first clock edge that samples `lvl_high` raises `trim_code` by one.
- R3: While stepping is enabled and the pin was last at mid, the first clock edge that samples `lvl_low` lowers `trim_code` by one.
- R4: `trim_code` stays at 127 on an increment and stays at 0 on a decrement. It never wraps.
- R5: Holding high or low gives exactly one step. Moving from low to high, or from high to low, without passing through mid gives no step.
- R6: While `chip_en` is low, step levels and program level change neither the code nor the store. A high or low level reached while disabled does not step the code after `chip_en` returns.
- R7: A write is started only on the (QUAL+1)-th consecutive edge with `lvl_prog` and `chip_en` high, where QUAL = CLK_HZ/1000*200/1000 cycles. A shorter or interrupted hold starts nothing, and one hold starts at most one write.
- R8: `nv_wr_req` stays high until `nv_busy` is seen. The block then waits until `nv_busy` falls. Steps requested during that time are ignored.
- R9: `nv_wr_data` equals `trim_code` as it was on the edge where the program command qualified, and stays stable while `nv_wr_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en | input | 1 | Enables stepping and programming |
| lvl_low | input | 1 | Pin is at low level |
| lvl_mid | input | 1 | Pin is at mid level |
| lvl_high | input | 1 | Pin is at high level |
| lvl_prog | input | 1 | Pin is at program (overvoltage) level |
| nv_rd_req | output | 1 | Read request to the store during restore |
| nv_rd_valid | input | 1 | Read data valid, one cycle |
| nv_rd_blank | input | 1 | Store holds no code; qualifies `nv_rd_valid` |
| nv_rd_data | input | CODE_W | Code returned by the store |
| nv_wr_req | output | 1 | Write request, held until busy is seen |
| nv_wr_data | output | CODE_W | Code to be written |
| nv_busy | input | 1 | Store write in progress |
| trim_code | output | CODE_W | Current trim code |

## Verification
The stepping path runs through a table of pin levels that mixes clean mid-high-mid and mid-low-mid cycles with held levels, direct low-to-high swings and levels reached while chip enable is low. The table separates edge-with-re-arm behaviour from simple level sensitivity. Saturation runs start from restored codes next to each end, so a wrapping counter shows up at once. The program path uses holds of exactly QUAL edges, QUAL+1 or more edges, an interrupted hold and a disabled hold. These pin the qualification boundary to one cycle. Steps attempted while the store is busy, followed by a reset that reads the written code back, tie the write data to the code at the moment of qualification.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [1:0] {
    ST_RESTORE = 2'd0,
    ST_IDLE    = 2'd1,
    ST_WR_REQ  = 2'd2,
    ST_WR_WAIT = 2'd3
  } trim_st_e;

  function automatic int unsigned qual_cycles(input int unsigned clk_hz,
                                              input int unsigned hold_us);
    int unsigned q;
    q = (clk_hz / 1000) * hold_us / 1000;
    return (q < 1) ? 1 : q;
  endfunction

endpackage

// File: rtl/trim_rst_sync.sv
module trim_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_s = s2_q;
endmodule

// File: rtl/trim_step_det.sv
module trim_step_det (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl_low,
  input  logic lvl_mid,
  input  logic lvl_high,
  output logic inc,
  output logic dec
);
  logic armed_q, armed_d;

  // Re-arm only at mid; any excursion to high or low consumes the arm.
  always_comb begin
    armed_d = armed_q;
    if (lvl_mid)                  armed_d = 1'b1;
    else if (lvl_high || lvl_low) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign inc = en && armed_q && lvl_high && !lvl_mid && !lvl_low;
  assign dec = en && armed_q && lvl_low  && !lvl_mid && !lvl_high;
endmodule

// File: rtl/trim_prog_qual.sv
module trim_prog_qual #(
  parameter int unsigned QUAL = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic prog_lvl,
  output logic fire
);
  localparam int unsigned CW = $clog2(QUAL + 2);
  localparam logic [CW-1:0] QV   = CW'(QUAL);
  localparam logic [CW-1:0] DONE = CW'(QUAL + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!(en && prog_lvl))  cnt_d = '0;
    else if (cnt_q != DONE) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Fires once, on the (QUAL+1)-th consecutive qualifying sample.
  assign fire = en && prog_lvl && (cnt_q == QV);
endmodule

// File: rtl/trim_code_reg.sv
module trim_code_reg #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] load_val,
  input  logic              inc,
  input  logic              dec,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MAXV = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] MIDV = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    code_d  = code_q;
    code_en = 1'b0;
    if (load) begin
      code_d  = load_val;
      code_en = 1'b1;
    end else if (inc && (code_q != MAXV)) begin
      code_d  = code_q + 1'b1;
      code_en = 1'b1;
    end else if (dec && (code_q != '0)) begin
      code_d  = code_q - 1'b1;
      code_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= MIDV;
    else if (code_en) code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/trim_ctl_top.sv
module trim_ctl_top
  import trim_pkg::*;
#(
  parameter int unsigned CODE_W  = 7,
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned HOLD_US = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              lvl_low,
  input  logic              lvl_mid,
  input  logic              lvl_high,
  input  logic              lvl_prog,
  output logic              nv_rd_req,
  input  logic              nv_rd_valid,
  input  logic              nv_rd_blank,
  input  logic [CODE_W-1:0] nv_rd_data,
  output logic              nv_wr_req,
  output logic [CODE_W-1:0] nv_wr_data,
  input  logic              nv_busy,
  output logic [CODE_W-1:0] trim_code
);
  localparam int unsigned QUAL = qual_cycles(CLK_HZ, HOLD_US);
  localparam logic [CODE_W-1:0] MIDV = {1'b1, {(CODE_W-1){1'b0}}};

  logic              rst_n_s;
  trim_st_e          st_q, st_d;
  logic              idle, step_en, prog_fire, wr_cap;
  logic              inc_raw, dec_raw, load;
  logic [CODE_W-1:0] load_val, wr_data_q;

  trim_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign idle    = (st_q == ST_IDLE);
  assign step_en = chip_en && idle && !wr_cap;

  trim_step_det u_step (
    .clk(clk), .rst_n(rst_n_s), .en(step_en),
    .lvl_low(lvl_low), .lvl_mid(lvl_mid), .lvl_high(lvl_high),
    .inc(inc_raw), .dec(dec_raw)
  );

  trim_prog_qual #(.QUAL(QUAL)) u_qual (
    .clk(clk), .rst_n(rst_n_s), .en(chip_en),
    .prog_lvl(lvl_prog), .fire(prog_fire)
  );

  trim_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n_s), .load(load), .load_val(load_val),
    .inc(inc_raw), .dec(dec_raw), .code(trim_code)
  );

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    wr_cap   = 1'b0;
    load_val = nv_rd_blank ? MIDV : nv_rd_data;
    case (st_q)
      ST_RESTORE: if (nv_rd_valid) begin
                    load = 1'b1;
                    st_d = ST_IDLE;
                  end
      ST_IDLE:    if (prog_fire) begin
                    wr_cap = 1'b1;
                    st_d   = ST_WR_REQ;
                  end
      ST_WR_REQ:  if (nv_busy)  st_d = ST_WR_WAIT;
      ST_WR_WAIT: if (!nv_busy) st_d = ST_IDLE;
      default:    st_d = ST_RESTORE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= ST_RESTORE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    wr_data_q <= '0;
    else if (wr_cap) wr_data_q <= trim_code;
  end

  assign nv_rd_req  = (st_q == ST_RESTORE);
  assign nv_wr_req  = (st_q == ST_WR_REQ);
  assign nv_wr_data = wr_data_q;
endmodule

// File: rtl/trim_ctl_chk.sv
module trim_ctl_chk #(
  parameter int unsigned CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              nv_rd_req,
  input logic              nv_wr_req,
  input logic [CODE_W-1:0] nv_wr_data,
  input logic              nv_busy,
  input logic [CODE_W-1:0] trim_code
);
  localparam logic [CODE_W-1:0] MAXV = {CODE_W{1'b1}};

  // R4: no wrap at the top of the range
  assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nv_rd_req && trim_code == MAXV) |=> (trim_code != '0));

  // R4: no wrap at the bottom of the range
  assert_no_wrap_bot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nv_rd_req && trim_code == '0) |=> (trim_code != MAXV));

  // R2, R3: outside restore the code moves by at most one step
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!nv_rd_req) |=> ((trim_code == $past(trim_code)) ||
                      (trim_code == $past(trim_code) + 1'b1) ||
                      (trim_code == $past(trim_code) - 1'b1)));

  // R6: disabled means the code holds
  assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !nv_rd_req) |=> $stable(trim_code));

  // R8: code holds while the store is busy
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> $stable(trim_code));

  // R8: request held until the store acknowledges
  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_wr_req && !nv_busy) |=> nv_wr_req);

  // R9: write data stable while requested
  assert_wr_data_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_wr_req && $past(nv_wr_req)) |-> $stable(nv_wr_data));
endmodule

bind trim_ctl_top trim_ctl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .nv_rd_req(nv_rd_req),
  .nv_wr_req(nv_wr_req), .nv_wr_data(nv_wr_data), .nv_busy(nv_busy),
  .trim_code(trim_code)
);

// File: tb/sim_trim_ctl_top.sv
module sim_trim_ctl_top;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chip_en, lvl_low, lvl_mid, lvl_high, lvl_prog;
  logic          nv_rd_req, nv_rd_valid, nv_rd_blank, nv_wr_req, nv_busy;
  logic [CW-1:0] nv_rd_data, nv_wr_data, trim_code;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // store model state
  logic [CW-1:0] st_val;
  logic          st_blank;
  int            bcnt, rwait, wr_cnt;
  logic [CW-1:0] last_wr;
  bit            preset_en;
  logic [CW-1:0] preset_val;
  bit            preset_blank;

  always #4 clk = ~clk;

  trim_ctl_top #(.CODE_W(CW), .CLK_HZ(100_000), .HOLD_US(200)) u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
    .lvl_low(lvl_low), .lvl_mid(lvl_mid), .lvl_high(lvl_high), .lvl_prog(lvl_prog),
    .nv_rd_req(nv_rd_req), .nv_rd_valid(nv_rd_valid), .nv_rd_blank(nv_rd_blank),
    .nv_rd_data(nv_rd_data), .nv_wr_req(nv_wr_req), .nv_wr_data(nv_wr_data),
    .nv_busy(nv_busy), .trim_code(trim_code)
  );

  // Non-volatile store model, driven at the falling edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      if (preset_en) begin
        st_val   = preset_val;
        st_blank = preset_blank;
      end
      nv_busy     = 1'b0;
      nv_rd_valid = 1'b0;
      bcnt        = 0;
      rwait       = 0;
    end else begin
      if (nv_wr_req && !nv_busy) begin
        nv_busy  = 1'b1;
        bcnt     = 8;
        st_val   = nv_wr_data;
        st_blank = 1'b0;
        last_wr  = nv_wr_data;
        wr_cnt   = wr_cnt + 1;
      end else if (nv_busy) begin
        bcnt = bcnt - 1;
        if (bcnt == 0) nv_busy = 1'b0;
      end
      if (nv_rd_valid) begin
        nv_rd_valid = 1'b0;
        rwait       = 0;
      end else if (nv_rd_req) begin
        rwait = rwait + 1;
        if (rwait == 3) begin
          nv_rd_valid = 1'b1;
          nv_rd_data  = st_val;
          nv_rd_blank = st_blank;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lvl: 0 low, 1 mid, 2 high, 3 program
  task automatic set_lvl(input int lvl);
    lvl_low  = (lvl == 0);
    lvl_mid  = (lvl == 1);
    lvl_high = (lvl == 2);
    lvl_prog = (lvl == 3);
  endtask

  task automatic step(input int lvl);
    @(negedge clk);
    set_lvl(lvl);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit pre, input int val, input bit blank);
    preset_en    = pre;
    preset_val   = CW'(val);
    preset_blank = blank;
    @(negedge clk);
    rst_n   = 1'b0;
    chip_en = 1'b1;
    set_lvl(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hold_prog(input int edges);
    @(negedge clk);
    set_lvl(3);
    repeat (edges) @(negedge clk);
    set_lvl(1);
  endtask

  // {lvl[1:0], en, expected code[6:0]}
  localparam logic [9:0] VEC [16] = '{
    {2'd1, 1'b1, 7'd64},  // R2 arm at mid
    {2'd2, 1'b1, 7'd65},  // R2 mid->high
    {2'd2, 1'b1, 7'd65},  // R5 held high
    {2'd1, 1'b1, 7'd65},
    {2'd2, 1'b1, 7'd66},  // R2
    {2'd1, 1'b1, 7'd66},
    {2'd0, 1'b1, 7'd65},  // R3 mid->low
    {2'd0, 1'b1, 7'd65},  // R5 held low
    {2'd1, 1'b1, 7'd65},
    {2'd0, 1'b1, 7'd64},  // R3
    {2'd2, 1'b1, 7'd64},  // R5 low->high no step
    {2'd1, 1'b0, 7'd64},  // R6
    {2'd2, 1'b0, 7'd64},  // R6 disabled step
    {2'd2, 1'b1, 7'd64},  // R6 consumed while disabled
    {2'd1, 1'b1, 7'd64},
    {2'd2, 1'b1, 7'd65}   // R2
  };

  initial begin
    rst_n = 1'b0; chip_en = 1'b0; set_lvl(1);
    wr_cnt = 0; last_wr = '0; st_val = '0; st_blank = 1'b1;
    nv_rd_data = '0; nv_rd_blank = 1'b0;

    // R1: blank store loads mid-scale
    do_reset(1'b1, 0, 1'b1);
    @(negedge clk);
    check("R1 read request after reset", int'(nv_rd_req), 1);
    repeat (10) @(negedge clk);
    check("R1 blank restore", int'(trim_code), 64);
    check("R1 read request dropped", int'(nv_rd_req), 0);

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chip_en = VEC[i][7];
      set_lvl(int'(VEC[i][9:8]));
      @(negedge clk);
      check($sformatf("R2 R3 R5 R6 row %0d", i), int'(trim_code), int'(VEC[i][6:0]));
    end
    chip_en = 1'b1;

    // R1: steps during restore ignored, stored value loaded
    do_reset(1'b1, 30, 1'b0);
    @(negedge clk);
    set_lvl(2);
    repeat (10) @(negedge clk);
    check("R1 restore value, early step ignored", int'(trim_code), 30);
    step(1); step(2);
    check("R2 step after restore", int'(trim_code), 31);

    // R4 top saturation
    do_reset(1'b1, 125, 1'b0);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 4; k++) begin step(1); step(2); end
    check("R4 saturate at 127", int'(trim_code), 127);

    // R4 bottom saturation
    do_reset(1'b1, 2, 1'b0);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 4; k++) begin step(1); step(0); end
    check("R4 saturate at 0", int'(trim_code), 0);

    // program path
    do_reset(1'b1, 40, 1'b0);
    repeat (10) @(negedge clk);
    wr_cnt = 0;
    hold_prog(20);
    repeat (30) @(negedge clk);
    check("R7 hold of exactly QUAL edges ignored", wr_cnt, 0);
    hold_prog(15);
    @(negedge clk);
    hold_prog(15);
    repeat (30) @(negedge clk);
    check("R7 interrupted hold ignored", wr_cnt, 0);
    chip_en = 1'b0;
    hold_prog(30);
    repeat (5) @(negedge clk);
    chip_en = 1'b1;
    repeat (30) @(negedge clk);
    check("R6 program while disabled ignored", wr_cnt, 0);

    hold_prog(25);
    @(negedge clk); set_lvl(2);
    @(negedge clk);
    check("R8 step during busy ignored", int'(trim_code), 40);
    check("R7 write started", wr_cnt, 1);
    check("R9 write data", int'(last_wr), 40);
    repeat (20) @(negedge clk);
    check("R8 busy released", int'(nv_busy), 0);
    step(1); step(2);
    check("R8 step after write", int'(trim_code), 41);
    check("R7 one write per hold", wr_cnt, 1);

    hold_prog(40);
    repeat (30) @(negedge clk);
    check("R7 second write", wr_cnt, 2);
    check("R9 second write data", int'(last_wr), 41);

    do_reset(1'b0, 0, 1'b0);
    repeat (10) @(negedge clk);
    check("R1 R9 written code restored", int'(trim_code), 41);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule